// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for every received frame, whether the frame is kept or dropped, judging only by its 48-bit destination address. The receive path hands the address to the block one byte per cycle, first byte first, with a marker on the first byte. Once the sixth byte has been taken, the block produces a one-cycle verdict that the downstream frame logic uses to either store or discard the rest of the frame.

There are four rules. Promiscuous operation keeps everything. The all-ones address is kept only when broadcast reception is enabled. A group (multicast) address is kept when one bit of a 64-bit table is set. That bit is picked by the upper six bits of a CRC-32 run over the six address bytes. Any other address is kept only when it equals the programmed station address in all 48 bits. The configuration inputs are plain levels, normally driven by a register block elsewhere. They are sampled on the clock edge that takes the sixth byte.

Top module: `eth_dst_filter`

## Requirements
- R1: While `rst` is high, and afterwards until a complete address has arrived, `dec_valid` is 0.
- R2: A byte is taken on a rising edge with `byte_valid`=1. A byte with `first_byte`=1 is always taken as address byte 0 and restarts collection, even in the middle of an address. A byte with `first_byte`=0 is taken as the next address byte only while fewer than six bytes have been collected. Cycles with `byte_valid`=0 are skipped, so gaps between bytes are allowed.
- R3: `dec_valid` is 1 for exactly the one cycle after the edge that takes the sixth byte. Further bytes without `first_byte` produce no decision.
- R4: The station address is formed as byte 0 = `station_hi[15:8]`, byte 1 = `station_hi[7:0]`, byte 2 = `station_lo[31:24]`, byte 3 = `station_lo[23:16]`, byte 4 = `station_lo[15:8]` and byte 5 = `station_lo[7:0]`, where byte 0 is the first byte received. A unicast address is accepted only when all 48 bits equal it.
- R5: The address FF:FF:FF:FF:FF:FF is accepted when `bcast_en`=1 and rejected when `bcast_en`=0 (unless R9 applies).
- R6: An address is multicast when bit 0 of byte 0 is 1 and it is not all ones. Multicast addresses are decided only by the hash table. Unicast addresses never consult the hash table.
- R7: The hash index is bits 31:26 of a CRC-32 register run over bytes 0..5. The register uses the reflected polynomial 0xEDB88320, starts at 0xFFFFFFFF, takes each byte least significant bit first, and is not inverted at the end.
- R8: Index bit 5 = 1 selects `hash_hi` and index bit 5 = 0 selects `hash_lo`. Index bits 4:0 give the bit position within the selected word. The frame is accepted when that bit is 1.
- R9: With `promisc`=1 every decision is accept.
- R10: With both hash words all ones, every multicast address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | An address byte is present on `byte_data` |
| first_byte | input | 1 | Marks byte 0 of a destination address |
| byte_data | input | 8 | Address byte |
| station_lo | input | 32 | Station address bytes 2..5 |
| station_hi | input | 16 | Station address bytes 0..1 |
| hash_lo | input | 32 | Hash table bits for index 0..31 |
| hash_hi | input | 32 | Hash table bits for index 32..63 |
| promisc | input | 1 | Accept every frame |
| bcast_en | input | 1 | Accept the all-ones address |
| dec_valid | output | 1 | Verdict present this cycle |
| dec_accept | output | 1 | Verdict: 1 keep, 0 drop |

## Verification
The bench drives the station address exactly and with single-bit differences in the first and last byte, which separates a full 48-bit compare from a partial one. Broadcast is tried with `bcast_en` set and cleared. Multicast addresses are chosen so that their hash index lands in each of the two hash words, and each is tried with its own bit set, with only the same position set in the other word, and with full tables. This separates a correct CRC and word select from a swapped or shifted one. Gapped bytes, a restart in the middle of an address, surplus bytes and back-to-back frames check the byte counting. Promiscuous runs use addresses that every other rule rejects.

// File: rtl/eth_af_pkg.sv
package eth_af_pkg;

    localparam int MAC_BYTES  = 6;
    localparam int MAC_W      = MAC_BYTES * 8;
    localparam int CRC_W      = 32;
    localparam int HASH_BITS  = 64;
    localparam int HASH_IDX_W = $clog2(HASH_BITS);
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_INIT = '1;

    typedef logic [MAC_W-1:0] mac_t;

    typedef enum logic [1:0] {
        DST_UNICAST   = 2'd0,
        DST_MULTICAST = 2'd1,
        DST_BROADCAST = 2'd2
    } dst_kind_e;

    typedef struct packed {
        logic valid;
        logic accept;
    } verdict_t;

    // One byte through the reflected CRC register, low bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0] crc_in,
        input logic [7:0]       data
    );
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ data[i]) c = (c >> 1) ^ CRC_POLY;
            else                c = c >> 1;
        end
        return c;
    endfunction

    // Byte 0 sits in the top byte of the packed address.
    function automatic dst_kind_e classify(input mac_t a);
        if (&a)              return DST_BROADCAST;
        else if (a[MAC_W-8]) return DST_MULTICAST;
        else                 return DST_UNICAST;
    endfunction

endpackage

// File: rtl/af_collect.sv
module af_collect
    import eth_af_pkg::*;
#(
    parameter int NB = MAC_BYTES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  byte_valid,
    input  logic                  first_byte,
    input  logic [7:0]            byte_data,
    output logic                  last_byte,
    output mac_t                  addr_full,
    output logic [HASH_IDX_W-1:0] hash_idx
);
    localparam int CNT_W = $clog2(NB + 1);
    localparam logic [CNT_W-1:0] IDLE = CNT_W'(NB);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NB - 1);

    logic [CNT_W-1:0] idx_q, pos;
    logic [CRC_W-1:0] crc_q, crc_in, crc_nx;
    mac_t             addr_q, addr_nx;
    logic             take;

    always_comb begin
        take    = byte_valid && (first_byte || idx_q != IDLE);
        pos     = first_byte ? '0 : idx_q;
        crc_in  = first_byte ? CRC_INIT : crc_q;
        crc_nx  = crc_step_byte(crc_in, byte_data);
        addr_nx = {addr_q[MAC_W-9:0], byte_data};
    end

    assign last_byte = take && (pos == LAST);
    assign addr_full = addr_nx;
    assign hash_idx  = crc_nx[CRC_W-1 -: HASH_IDX_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= IDLE;
            crc_q  <= CRC_INIT;
            addr_q <= '0;
        end else if (take) begin
            idx_q  <= pos + 1'b1;
            crc_q  <= crc_nx;
            addr_q <= addr_nx;
        end
    end

    // Surplus bytes without a start marker leave the collector idle.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (idx_q == IDLE && !first_byte) |=> (idx_q == IDLE));

endmodule

// File: rtl/af_hash_lookup.sv
module af_hash_lookup
    import eth_af_pkg::*;
(
    input  logic [HASH_IDX_W-1:0] idx,
    input  logic [31:0]           hash_lo,
    input  logic [31:0]           hash_hi,
    output logic                  hit
);
    logic [HASH_BITS-1:0] table_w;

    // Upper index bit chooses the high word.
    assign table_w = {hash_hi, hash_lo};
    assign hit     = table_w[idx];

endmodule

// File: rtl/af_decide.sv
module af_decide
    import eth_af_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  last_byte,
    input  mac_t                  addr,
    input  logic [HASH_IDX_W-1:0] hash_idx,
    input  logic [31:0]           station_lo,
    input  logic [15:0]           station_hi,
    input  logic [31:0]           hash_lo,
    input  logic [31:0]           hash_hi,
    input  logic                  promisc,
    input  logic                  bcast_en,
    output verdict_t              verdict
);
    mac_t      station;
    dst_kind_e kind;
    logic      hash_hit;
    logic      keep;

    af_hash_lookup u_hash (
        .idx     (hash_idx),
        .hash_lo (hash_lo),
        .hash_hi (hash_hi),
        .hit     (hash_hit)
    );

    always_comb begin
        station = {station_hi, station_lo};
        kind    = classify(addr);
        if (promisc) keep = 1'b1;
        else begin
            unique case (kind)
                DST_BROADCAST: keep = bcast_en;
                DST_MULTICAST: keep = hash_hit;
                default:       keep = (addr == station);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) verdict <= '0;
        else begin
            verdict.valid  <= last_byte;
            verdict.accept <= last_byte && keep;
        end
    end

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        verdict.valid |=> !verdict.valid);

    assert_bcast_block_R5: assert property (@(posedge clk) disable iff (rst)
        (last_byte && (&addr) && !promisc && !bcast_en)
            |=> (verdict.valid && !verdict.accept));

endmodule

// File: rtl/eth_dst_filter.sv
module eth_dst_filter
    import eth_af_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_valid,
    input  logic        first_byte,
    input  logic [7:0]  byte_data,
    input  logic [31:0] station_lo,
    input  logic [15:0] station_hi,
    input  logic [31:0] hash_lo,
    input  logic [31:0] hash_hi,
    input  logic        promisc,
    input  logic        bcast_en,
    output logic        dec_valid,
    output logic        dec_accept
);
    logic                  last_byte;
    mac_t                  addr_full;
    logic [HASH_IDX_W-1:0] hash_idx;
    verdict_t              verdict;

    af_collect #(.NB(MAC_BYTES)) u_collect (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .first_byte (first_byte),
        .byte_data  (byte_data),
        .last_byte  (last_byte),
        .addr_full  (addr_full),
        .hash_idx   (hash_idx)
    );

    af_decide u_decide (
        .clk        (clk),
        .rst        (rst),
        .last_byte  (last_byte),
        .addr       (addr_full),
        .hash_idx   (hash_idx),
        .station_lo (station_lo),
        .station_hi (station_hi),
        .hash_lo    (hash_lo),
        .hash_hi    (hash_hi),
        .promisc    (promisc),
        .bcast_en   (bcast_en),
        .verdict    (verdict)
    );

    assign dec_valid  = verdict.valid;
    assign dec_accept = verdict.accept;

    assert_valid_follows_byte_R3: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(byte_valid));

    assert_promisc_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && $past(promisc)) |-> dec_accept);

endmodule

// File: tb/sim_eth_dst_filter.sv
module sim_eth_dst_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bv = 1'b0, fb = 1'b0;
    logic [7:0]  bd = 8'h00;
    logic [31:0] st_lo = 32'h0, hl = 32'h0, hh = 32'h0;
    logic [15:0] st_hi = 16'h0;
    logic        prom = 1'b0, bce = 1'b0;
    logic        dv, da;

    int tests = 0, fails = 0;

    always #10 clk = ~clk;

    eth_dst_filter u0 (
        .clk(clk), .rst(rst), .byte_valid(bv), .first_byte(fb), .byte_data(bd),
        .station_lo(st_lo), .station_hi(st_hi), .hash_lo(hl), .hash_hi(hh),
        .promisc(prom), .bcast_en(bce), .dec_valid(dv), .dec_accept(da)
    );

    // Table-driven reference CRC.
    logic [31:0] crc_tbl [256];
    initial begin
        for (int n = 0; n < 256; n++) begin
            logic [31:0] c;
            c = 32'(n);
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
            crc_tbl[n] = c;
        end
    end

    function automatic int ref_index(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int k = 0; k < 6; k++)
            c = (c >> 8) ^ crc_tbl[(c[7:0] ^ a[47-8*k -: 8])];
        return int'(c[31:26]);
    endfunction

    // Behavioural reference, updated on every rising edge.
    logic [7:0] m_b [6];
    int         m_cnt = 6;
    logic       m_v = 1'b0, m_a = 1'b0;
    string      m_tag = "R3";

    always @(posedge clk) begin
        logic took;
        logic [47:0] a;
        int ix;
        logic hbit;
        took = 1'b0;
        m_v = 1'b0;
        m_a = 1'b0;
        if (rst) m_cnt = 6;
        else if (bv) begin
            if (fb) begin m_b[0] = bd; m_cnt = 1; end
            else if (m_cnt < 6) begin m_b[m_cnt] = bd; m_cnt++; took = 1'b1; end
        end
        if (took && m_cnt == 6) begin
            a = {m_b[0], m_b[1], m_b[2], m_b[3], m_b[4], m_b[5]};
            ix = ref_index(a);
            hbit = (ix >= 32) ? hh[ix-32] : hl[ix];
            m_v = 1'b1;
            if (prom) begin m_a = 1'b1; m_tag = "R9"; end
            else if (a == 48'hFFFFFFFFFFFF) begin m_a = bce; m_tag = "R5"; end
            else if (a[40]) begin m_a = hbit; m_tag = "R6/R7"; end
            else begin m_a = (a == {st_hi, st_lo}); m_tag = "R4"; end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            tests++;
            if (dv !== m_v) begin
                fails++;
                $display("FAIL R3 dec_valid actual=%b expected=%b at %0t", dv, m_v, $time);
            end else if (m_v && da !== m_a) begin
                fails++;
                $display("FAIL %s dec_accept actual=%b expected=%b at %0t", m_tag, da, m_a, $time);
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic send(input logic [47:0] a, input int gap);
        for (int k = 0; k < 6; k++) begin
            bv = 1'b1; fb = (k == 0); bd = a[47-8*k -: 8];
            @(negedge clk);
            if (gap > 0 && k < 5) begin
                bv = 1'b0; fb = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
        bv = 1'b0; fb = 1'b0;
    endtask

    // After send() returns, the verdict is on the outputs.
    task automatic expect_dec(input logic exp, input string tag);
        chk(dv, 1'b1, tag);
        chk(da, exp, tag);
        @(negedge clk);
        chk(dv, 1'b0, "R3");
    endtask

    localparam logic [47:0] STA = 48'h021122334455;
    localparam logic [47:0] BC  = 48'hFFFFFFFFFFFF;

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R3 actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [47:0] mc_lo, mc_hi;
        int ix_lo, ix_hi;
        mc_lo = 48'h0; mc_hi = 48'h0; ix_lo = -1; ix_hi = -1;
        for (int n = 0; n < 200 && (ix_lo < 0 || ix_hi < 0); n++) begin
            logic [47:0] c;
            int ix;
            c = 48'h01005E000000 + 48'(n);
            ix = ref_index(c);
            if (ix < 32 && ix_lo < 0) begin mc_lo = c; ix_lo = ix; end
            if (ix >= 32 && ix_hi < 0) begin mc_hi = c; ix_hi = ix; end
        end

        st_hi = STA[47:32]; st_lo = STA[31:0]; bce = 1'b1;
        repeat (3) @(negedge clk);
        chk(dv, 1'b0, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        chk(dv, 1'b0, "R1 after reset");

        // R2: bytes without a start marker never form an address.
        for (int k = 0; k < 6; k++) begin bv = 1'b1; fb = 1'b0; bd = STA[47-8*k -: 8]; @(negedge clk); end
        bv = 1'b0;
        chk(dv, 1'b0, "R2 no start marker");
        @(negedge clk);

        send(STA, 0);                expect_dec(1'b1, "R4 exact match");
        send(STA ^ 48'h1, 0);        expect_dec(1'b0, "R4 last byte differs");
        send(STA ^ 48'h040000000000, 0); expect_dec(1'b0, "R4 first byte differs");
        send(STA, 2);                expect_dec(1'b1, "R2 gapped bytes");

        // R2: restart in the middle of an address.
        for (int k = 0; k < 3; k++) begin bv = 1'b1; fb = (k == 0); bd = 8'hA0 + 8'(k); @(negedge clk); end
        send(STA, 0);                expect_dec(1'b1, "R2 restart mid address");

        // R3: surplus bytes produce no decision.
        send(STA, 0);                expect_dec(1'b1, "R4");
        for (int k = 0; k < 7; k++) begin bv = 1'b1; fb = 1'b0; bd = 8'h55; @(negedge clk); end
        bv = 1'b0;
        chk(dv, 1'b0, "R3 surplus bytes");
        @(negedge clk);

        send(BC, 0);                 expect_dec(1'b1, "R5 broadcast enabled");
        bce = 1'b0;
        send(BC, 0);                 expect_dec(1'b0, "R5 broadcast disabled");
        bce = 1'b1;

        send(mc_lo, 0);              expect_dec(1'b0, "R6 empty table");
        hl = 32'h1 << ix_lo;
        send(mc_lo, 0);              expect_dec(1'b1, "R7 low word bit");
        hl = 32'h0; hh = 32'h1 << ix_lo;
        send(mc_lo, 0);              expect_dec(1'b0, "R8 wrong word");
        hh = 32'h1 << (ix_hi - 32);
        send(mc_hi, 0);              expect_dec(1'b1, "R8 high word bit");
        hh = 32'h0; hl = 32'h1 << (ix_hi - 32);
        send(mc_hi, 0);              expect_dec(1'b0, "R8 high index in low word");

        hl = '1; hh = '1;
        send(48'h3300000000AB, 0);   expect_dec(1'b1, "R10 full table");
        send(mc_lo, 0);              expect_dec(1'b1, "R10 full table");
        send(STA ^ 48'h100, 0);      expect_dec(1'b0, "R6 unicast ignores table");
        hl = '0; hh = '0;

        prom = 1'b1; bce = 1'b0;
        send(STA ^ 48'h100, 0);      expect_dec(1'b1, "R9 unicast miss");
        send(BC, 0);                 expect_dec(1'b1, "R9 broadcast disabled");
        send(mc_hi, 0);              expect_dec(1'b1, "R9 multicast miss");
        prom = 1'b0; bce = 1'b1;

        // Back-to-back frames, checked by the per-cycle model.
        send(STA, 0);
        send(STA ^ 48'h8000, 0);
        send(BC, 0);
        repeat (3) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule